// File: doc/BRIEF.md
# SPI NOR Erase Sequencer

This block carries out erase operations on a serial NOR flash device. A requester gives it a start address, a byte length and a granularity choice. The block checks the request against the device geometry, then produces every flash command the erase needs. It sends them through a byte-level SPI master that has a chip-select line, a per-byte start pulse, a transmit byte, a receive byte and a byte-complete pulse. When the request finishes, the block raises exactly one result pulse: completed, timed out, or rejected.

Each erase command is prepared the same way. The block reads the status register repeatedly until the busy flag clears. It then sends the write-enable command as a separate transaction, and only then sends the erase command. A request that spans the whole device becomes one chip-wide erase. Any other request becomes a series of block erases, each carrying a three-byte address, with the address stepped by the erase unit. The erase unit is 4 KiB when fine granularity is requested and the device supports it. Otherwise it is the device sector.

A cycle counter watches each busy wait. If the device stays busy for too long, the operation is abandoned and reported as a failure.

Top module: `nor_erase_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `spi_cs` is 0, `spi_start` is 0, and none of `op_done`, `op_fail` or `op_reject` is asserted.
- R2: An accepted request whose address plus length exceeds the device size (N_SECTORS << SECTOR_LOG2 bytes) gives a one-cycle `op_reject` pulse one cycle after acceptance, and chip select is never raised.
- R3: An accepted request whose length is not a multiple of the erase unit is rejected in the same way as R2, with no SPI traffic. The erase unit is 4096 bytes when `req_fine`=1 and SMALL_OK=1, and 1 << SECTOR_LOG2 bytes otherwise.
- R4: Every erase frame is preceded by one or more status-read frames and then one write-enable frame. A status-read frame is two bytes: 0x05, then a 0x00 dummy. The status read repeats until bit 0 of the byte received in the second position is 0. The write-enable frame is the single byte 0x06.
- R5: A request whose length equals the device size produces exactly one erase frame, consisting of the single byte 0xC7.
- R6: Any other valid request of non-zero length produces length/unit erase frames. Each frame is four bytes: the erase opcode, then address bits 23:16, 15:8 and 7:0. The first frame carries the start address and each later frame adds one unit. `op_done` pulses after the last erase frame ends.
- R7: The erase opcode is 0x20 with a 4096-byte unit when `req_fine`=1. It is 0xD8 with a unit of 1 << SECTOR_LOG2 bytes when `req_fine`=0.
- R8: Each command is its own frame. `spi_start` is asserted only while `spi_cs` is 1 and lasts a single cycle. `spi_cs` stays low for at least one cycle after every fall.
- R9: If the status busy bit is still set after POLL_LIMIT cycles of polling, the block pulses `op_fail`. It sends no further write-enable or erase frame for that request.
- R10: A valid request of zero length gives `op_done` one cycle after acceptance, with no SPI traffic.
- R11: `req_ready` is low from acceptance until the result pulse. `req_valid` is ignored while `req_ready` is low, and chip select is never active while `req_ready` is high.
- R12: Each accepted request ends with exactly one of `op_done`, `op_fail` or `op_reject`, lasting one cycle. During that cycle `req_ready` is already 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Erase request present |
| req_addr | input | 24 | Start byte address |
| req_len | input | 25 | Length in bytes |
| req_fine | input | 1 | Request the 4 KiB erase unit |
| req_ready | output | 1 | Idle and able to accept a request |
| op_done | output | 1 | Request completed (pulse) |
| op_fail | output | 1 | Busy wait timed out (pulse) |
| op_reject | output | 1 | Request refused on range or alignment (pulse) |
| spi_cs | output | 1 | Chip select, active high, frames one command |
| spi_start | output | 1 | Start shifting `spi_tx_byte` (pulse) |
| spi_tx_byte | output | 8 | Byte to transmit |
| spi_byte_done | input | 1 | Byte exchange complete (pulse) |
| spi_rx_byte | input | 8 | Byte received, valid with `spi_byte_done` |

## Verification
Most internal faults show up in the command stream within a single frame. A wrong sequencer state produces a missing or extra status-read or write-enable frame. A bad address register produces a wrong address byte in the next erase frame. Both are caught when chip select falls at the end of that frame. A stuck busy decision either hangs the block or skips the wait, and the next frame to appear is then the wrong kind. Planner faults show up one cycle after acceptance, as the wrong result pulse or as chip select rising when a refusal was expected.

// File: rtl/nor_erase_pkg.sv
package nor_erase_pkg;

    localparam int ADDR_W    = 24;
    localparam int LEN_W     = ADDR_W + 1;
    localparam int FRAME_MAX = 4;
    localparam int NB_W      = $clog2(FRAME_MAX + 1);
    localparam int FINE_LOG2 = 12;
    localparam int BUSY_BIT  = 0;

    localparam logic [7:0] OP_WREN       = 8'h06;
    localparam logic [7:0] OP_RDSR       = 8'h05;
    localparam logic [7:0] OP_CHIP       = 8'hC7;
    localparam logic [7:0] OP_ERASE_FINE = 8'h20;
    localparam logic [7:0] OP_ERASE_SECT = 8'hD8;

    typedef struct packed {
        logic [NB_W-1:0]              nbytes;
        logic [FRAME_MAX-1:0][7:0]    bytes;
    } frame_t;

    typedef struct packed {
        logic              ok;
        logic              empty;
        logic              chip;
        logic [7:0]        opcode;
        logic [LEN_W-1:0]  count;
        logic [ADDR_W-1:0] step;
    } plan_t;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_POLL, SQ_POLL_W, SQ_WREN, SQ_WREN_W, SQ_ERASE, SQ_ERASE_W
    } seq_state_e;

    typedef enum logic [1:0] {
        FE_IDLE, FE_SEND, FE_WAIT, FE_END
    } fe_state_e;

    function automatic frame_t single_frame(input logic [7:0] op);
        frame_t f;
        f          = '0;
        f.nbytes   = NB_W'(1);
        f.bytes[0] = op;
        return f;
    endfunction

    function automatic frame_t status_frame();
        frame_t f;
        f          = '0;
        f.nbytes   = NB_W'(2);
        f.bytes[0] = OP_RDSR;
        f.bytes[1] = 8'h00;
        return f;
    endfunction

    function automatic frame_t block_frame(input logic [7:0] op,
                                           input logic [ADDR_W-1:0] a);
        frame_t f;
        f.nbytes   = NB_W'(4);
        f.bytes[0] = op;
        f.bytes[1] = a[23:16];
        f.bytes[2] = a[15:8];
        f.bytes[3] = a[7:0];
        return f;
    endfunction

endpackage

// File: rtl/erase_planner.sv
module erase_planner
    import nor_erase_pkg::*;
#(
    parameter int SECTOR_LOG2 = 16,
    parameter int N_SECTORS   = 4,
    parameter int SMALL_OK    = 1
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  len,
    input  logic              fine,
    output plan_t             plan
);
    localparam logic [63:0] DEV_W       = 64'(N_SECTORS) << SECTOR_LOG2;
    localparam logic [LEN_W:0] DEV_BYTES = DEV_W[LEN_W:0];
    localparam logic [63:0] SECT_W      = 64'd1 << SECTOR_LOG2;
    localparam logic [63:0] FINE_W      = 64'd1 << FINE_LOG2;
    localparam logic [63:0] SECT_MASK_W = SECT_W - 64'd1;
    localparam logic [63:0] FINE_MASK_W = FINE_W - 64'd1;

    logic              use_fine;
    logic [LEN_W:0]    end_sum;
    logic [LEN_W-1:0]  mask;

    generate
        if (SMALL_OK != 0) begin : g_fine
            assign use_fine = fine;
        end else begin : g_coarse
            logic unused_fine;
            assign unused_fine = fine;
            assign use_fine    = 1'b0;
        end
    endgenerate

    always_comb begin
        end_sum     = {2'b00, addr} + {1'b0, len};
        mask        = use_fine ? FINE_MASK_W[LEN_W-1:0] : SECT_MASK_W[LEN_W-1:0];
        plan.ok     = (end_sum <= DEV_BYTES) && ((len & mask) == '0);
        plan.empty  = (len == '0);
        plan.chip   = ({1'b0, len} == DEV_BYTES);
        plan.opcode = use_fine ? OP_ERASE_FINE : OP_ERASE_SECT;
        plan.count  = use_fine ? (len >> FINE_LOG2) : (len >> SECTOR_LOG2);
        plan.step   = use_fine ? FINE_W[ADDR_W-1:0] : SECT_W[ADDR_W-1:0];
    end

endmodule

// File: rtl/poll_timer.sv
module poll_timer #(
    parameter int LIMIT = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = $clog2(LIMIT + 1);

    logic [CNT_W-1:0] cnt;

    assign expired = (cnt >= CNT_W'(LIMIT));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + CNT_W'(1);
        end
    end

endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
    import nor_erase_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    input  frame_t     frame_in,
    input  logic       spi_byte_done,
    input  logic [7:0] spi_rx_byte,
    output logic       spi_cs,
    output logic       spi_start,
    output logic [7:0] spi_tx_byte,
    output logic       frame_done,
    output logic [7:0] rx_last
);
    localparam int IDX_W = $clog2(FRAME_MAX);

    fe_state_e       state;
    frame_t          frm;
    logic [NB_W-1:0] idx;

    assign spi_start   = (state == FE_SEND);
    assign frame_done  = (state == FE_END);
    assign spi_tx_byte = frm.bytes[idx[IDX_W-1:0]];

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= FE_IDLE;
            frm     <= '0;
            idx     <= '0;
            spi_cs  <= 1'b0;
            rx_last <= '0;
        end else begin
            case (state)
                FE_IDLE: begin
                    if (start) begin
                        frm    <= frame_in;
                        idx    <= '0;
                        spi_cs <= 1'b1;
                        state  <= FE_SEND;
                    end
                end
                FE_SEND: state <= FE_WAIT;
                FE_WAIT: begin
                    if (spi_byte_done) begin
                        rx_last <= spi_rx_byte;
                        if (idx == frm.nbytes - NB_W'(1)) begin
                            spi_cs <= 1'b0;
                            state  <= FE_END;
                        end else begin
                            idx   <= idx + NB_W'(1);
                            state <= FE_SEND;
                        end
                    end
                end
                default: state <= FE_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/nor_erase_seq.sv
module nor_erase_seq
    import nor_erase_pkg::*;
#(
    parameter int SECTOR_LOG2 = 16,
    parameter int N_SECTORS   = 4,
    parameter int SMALL_OK    = 1,
    parameter int POLL_LIMIT  = 100000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_fine,
    output logic              req_ready,
    output logic              op_done,
    output logic              op_fail,
    output logic              op_reject,
    output logic              spi_cs,
    output logic              spi_start,
    output logic [7:0]        spi_tx_byte,
    input  logic              spi_byte_done,
    input  logic [7:0]        spi_rx_byte
);
    seq_state_e        state;
    plan_t             plan;
    frame_t            frame_sel;
    logic [ADDR_W-1:0] cur_addr;
    logic [ADDR_W-1:0] step_q;
    logic [LEN_W-1:0]  left;
    logic              chip_q;
    logic [7:0]        op_q;
    logic              eng_start;
    logic              frame_done;
    logic [7:0]        rx_last;
    logic              poll_run;
    logic              poll_expired;
    logic              dev_busy;

    erase_planner #(
        .SECTOR_LOG2 (SECTOR_LOG2),
        .N_SECTORS   (N_SECTORS),
        .SMALL_OK    (SMALL_OK)
    ) u_plan (
        .addr (req_addr),
        .len  (req_len),
        .fine (req_fine),
        .plan (plan)
    );

    poll_timer #(.LIMIT(POLL_LIMIT)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (poll_run),
        .expired (poll_expired)
    );

    spi_frame_engine u_eng (
        .clk           (clk),
        .rst           (rst),
        .start         (eng_start),
        .frame_in      (frame_sel),
        .spi_byte_done (spi_byte_done),
        .spi_rx_byte   (spi_rx_byte),
        .spi_cs        (spi_cs),
        .spi_start     (spi_start),
        .spi_tx_byte   (spi_tx_byte),
        .frame_done    (frame_done),
        .rx_last       (rx_last)
    );

    assign req_ready = (state == SQ_IDLE);
    assign eng_start = (state == SQ_POLL) || (state == SQ_WREN) || (state == SQ_ERASE);
    assign poll_run  = (state == SQ_POLL) || (state == SQ_POLL_W);
    assign dev_busy  = rx_last[BUSY_BIT];

    always_comb begin
        case (state)
            SQ_POLL: frame_sel = status_frame();
            SQ_WREN: frame_sel = single_frame(OP_WREN);
            default: frame_sel = chip_q ? single_frame(OP_CHIP)
                                        : block_frame(op_q, cur_addr);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= SQ_IDLE;
            cur_addr  <= '0;
            step_q    <= '0;
            left      <= '0;
            chip_q    <= 1'b0;
            op_q      <= '0;
            op_done   <= 1'b0;
            op_fail   <= 1'b0;
            op_reject <= 1'b0;
        end else begin
            op_done   <= 1'b0;
            op_fail   <= 1'b0;
            op_reject <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (req_valid) begin
                        if (!plan.ok) begin
                            op_reject <= 1'b1;
                        end else if (plan.empty) begin
                            op_done <= 1'b1;
                        end else begin
                            cur_addr <= req_addr;
                            step_q   <= plan.step;
                            left     <= plan.count;
                            chip_q   <= plan.chip;
                            op_q     <= plan.opcode;
                            state    <= SQ_POLL;
                        end
                    end
                end
                SQ_POLL:  state <= SQ_POLL_W;
                SQ_POLL_W: begin
                    if (frame_done) begin
                        if (!dev_busy) begin
                            state <= SQ_WREN;
                        end else if (poll_expired) begin
                            op_fail <= 1'b1;
                            state   <= SQ_IDLE;
                        end else begin
                            state <= SQ_POLL;
                        end
                    end
                end
                SQ_WREN:  state <= SQ_WREN_W;
                SQ_WREN_W: begin
                    if (frame_done) state <= SQ_ERASE;
                end
                SQ_ERASE: state <= SQ_ERASE_W;
                SQ_ERASE_W: begin
                    if (frame_done) begin
                        if (chip_q || left == LEN_W'(1)) begin
                            op_done <= 1'b1;
                            state   <= SQ_IDLE;
                        end else begin
                            cur_addr <= cur_addr + step_q;
                            left     <= left - LEN_W'(1);
                            state    <= SQ_POLL;
                        end
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/nor_erase_seq_chk.sv
module nor_erase_seq_chk (
    input logic clk,
    input logic rst,
    input logic req_ready,
    input logic op_done,
    input logic op_fail,
    input logic op_reject,
    input logic spi_cs,
    input logic spi_start
);
    AST_START_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        spi_start |-> spi_cs); // R8
    AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
        spi_start |=> !spi_start); // R8
    AST_CS_GAP: assert property (@(posedge clk) disable iff (rst)
        $fell(spi_cs) |=> !spi_cs); // R8
    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (rst)
        $countones({op_done, op_fail, op_reject}) <= 1); // R12
    AST_RESULT_READY: assert property (@(posedge clk) disable iff (rst)
        (op_done || op_fail || op_reject) |-> req_ready); // R12
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !spi_cs); // R11
    AST_REJECT_QUIET: assert property (@(posedge clk) disable iff (rst)
        op_reject |=> !spi_cs); // R2
endmodule

bind nor_erase_seq nor_erase_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_ready (req_ready),
    .op_done   (op_done),
    .op_fail   (op_fail),
    .op_reject (op_reject),
    .spi_cs    (spi_cs),
    .spi_start (spi_start)
);

// File: tb/nor_erase_seq_test.sv
module nor_erase_seq_test;
    import nor_erase_pkg::*;

    localparam int SECT_LOG2 = 16;
    localparam int NSECT     = 4;
    localparam int LIMIT     = 300;
    localparam int BUSY_N    = 2;
    localparam int DEV       = NSECT << SECT_LOG2;
    localparam logic [39:0] RDSR_F = {8'd2, 8'h05, 8'h00, 16'h0000};

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic              req_fine = 1'b0;
    logic              req_ready, op_done, op_fail, op_reject;
    logic              spi_cs, spi_start;
    logic [7:0]        spi_tx_byte;
    logic              spi_byte_done = 1'b0;
    logic [7:0]        spi_rx_byte = 8'h00;

    nor_erase_seq #(
        .SECTOR_LOG2 (SECT_LOG2),
        .N_SECTORS   (NSECT),
        .SMALL_OK    (1),
        .POLL_LIMIT  (LIMIT)
    ) uut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_len(req_len), .req_fine(req_fine), .req_ready(req_ready),
        .op_done(op_done), .op_fail(op_fail), .op_reject(op_reject),
        .spi_cs(spi_cs), .spi_start(spi_start), .spi_tx_byte(spi_tx_byte),
        .spi_byte_done(spi_byte_done), .spi_rx_byte(spi_rx_byte)
    );

    int          vectors = 0;
    int          miscompares = 0;
    logic [39:0] expq[$];
    string       cur_tag = "R1";
    bit          lenient = 0;
    bit          stuck = 0;
    int          lenient_bad = 0;
    int          busy_left = 0;
    bit          wel = 0;
    int          exp_busy = 0;
    logic [7:0]  fb [4];
    int          fcnt = 0;
    bit          prev_cs = 0;
    int          pend = 0;
    logic [7:0]  resp = 8'h00;

    task automatic chk(input bit ok, input string r, input string what,
                       input longint act, input longint exp);
        vectors++;
        if (!ok) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
        end
    endtask

    // device model and frame monitor (scoreboard consumer)
    task automatic frame_end();
        logic [39:0] got;
        got = {8'(fcnt), fb[0], fb[1], fb[2], fb[3]};
        case (fb[0])
            8'h05: if (busy_left > 0) busy_left--;
            8'h06: wel = 1;
            8'h20, 8'hD8, 8'hC7: begin busy_left = BUSY_N; wel = 0; end
            default: ;
        endcase
        if (lenient) begin
            if (fb[0] != 8'h05) lenient_bad++;
        end else if (expq.size() == 0) begin
            chk(0, cur_tag, "unexpected frame", got, 0);
        end else begin
            logic [39:0] exp;
            exp = expq.pop_front();
            chk(got == exp, cur_tag, "frame", got, exp);
        end
        fcnt = 0;
        foreach (fb[i]) fb[i] = 8'h00;
    endtask

    always @(negedge clk) begin
        if (pend != 0) begin
            spi_byte_done = 1'b1;
            spi_rx_byte   = resp;
            pend          = 0;
        end else begin
            spi_byte_done = 1'b0;
        end
        if (!rst && spi_start) begin
            if (fcnt < 4) fb[fcnt] = spi_tx_byte;
            resp = (fcnt == 1 && fb[0] == 8'h05)
                 ? {6'b0, wel, (stuck || busy_left > 0)} : 8'hFF;
            fcnt++;
            pend = 1;
        end
        if (prev_cs && !spi_cs) frame_end();
        prev_cs = spi_cs;
    end

    // scoreboard producer
    task automatic push_op(input logic [39:0] erase_f);
        for (int i = 0; i <= exp_busy; i++) expq.push_back(RDSR_F);
        expq.push_back({8'd1, 8'h06, 24'h0});
        expq.push_back(erase_f);
        exp_busy = BUSY_N;
    endtask

    task automatic run_req(input int addr, input int len, input bit fine,
                           input bit poke, input bit exp_fail, input string tag);
        int unit;
        int kind;
        int got;
        int t;
        cur_tag = tag;
        unit = fine ? 4096 : (1 << SECT_LOG2);
        if (addr + len > DEV || (len % unit) != 0) begin
            kind = 2;
        end else if (exp_fail) begin
            kind = 1;
        end else begin
            kind = 0;
            if (len == DEV) push_op({8'd1, 8'hC7, 24'h0});
            else for (int k = 0; k < len / unit; k++) begin
                int a;
                a = addr + k * unit;
                push_op({8'd4, (fine ? 8'h20 : 8'hD8), 8'(a >> 16), 8'(a >> 8), 8'(a)});
            end
        end
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = ADDR_W'(addr);
        req_len   = LEN_W'(len);
        req_fine  = fine;
        @(negedge clk);
        req_valid = 1'b0;
        t = 0;
        while (!(op_done || op_fail || op_reject) && t < 50000) begin
            if (poke && t == 3) begin req_valid = 1'b1; req_len = LEN_W'(3); end
            if (poke && t == 8) req_valid = 1'b0;
            @(negedge clk);
            t++;
        end
        req_valid = 1'b0;
        got = op_reject ? 2 : op_fail ? 1 : op_done ? 0 : 3;
        chk(got == kind, tag, "result kind", got, kind);
        chk(req_ready == 1'b1, "R12", "ready at result", req_ready, 1);
        repeat (6) @(negedge clk);
        chk(expq.size() == 0, tag, "frames left", expq.size(), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        foreach (fb[i]) fb[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        chk(req_ready == 1'b1, "R1", "ready", req_ready, 1);
        chk(spi_cs == 1'b0 && spi_start == 1'b0, "R1", "spi idle", spi_cs, 0);
        chk({op_done, op_fail, op_reject} == 3'b000, "R1", "pulses", {op_done, op_fail, op_reject}, 0);

        run_req('h1000, 'h1000, 1, 0, 0, "R4");   // single fine block, one poll
        run_req('h3000, 'h3000, 1, 0, 0, "R6");   // three blocks, busy carried over
        run_req('h10000, 'h20000, 0, 0, 0, "R7"); // coarse 0xD8 sectors
        run_req(0, DEV, 1, 0, 0, "R5");           // whole device
        run_req('h3F000, 'h2000, 1, 0, 0, "R2");  // past the end
        run_req('h0, 'h800, 1, 0, 0, "R3");       // not 4K multiple
        run_req('h0, 'h1000, 0, 0, 0, "R3");      // not sector multiple
        run_req('h2000, 0, 1, 0, 0, "R10");       // empty request
        run_req('h30000, 'h10000, 0, 1, 0, "R11"); // busy-time request ignored

        stuck = 1; lenient = 1; lenient_bad = 0;
        run_req('h5000, 'h1000, 1, 0, 1, "R9");
        chk(lenient_bad == 0, "R9", "non-status frames after timeout", lenient_bad, 0);
        stuck = 0; lenient = 0; exp_busy = 0;

        run_req('h7000, 'h2000, 1, 0, 0, "R4");   // recovery after failure

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule